// File: doc/BRIEF.md
# Buffer-Occupancy Oscillator Trim Controller

This block sits beside a sample buffer that decouples an audio stream arriving with unstable timing from an output side clocked by a local tunable oscillator. It keeps the buffer near the middle of its range by moving the oscillator's frequency-control code. The code moves up when the buffer is filling and down when it is draining. Because the code depends only on buffer occupancy and a slow timer, the arrival timing of input samples never reaches the output clock. Only long-term frequency offset between the two sides is corrected.

Each correction is a single least-significant step of the code. A programmable hold-off interval, counted on the local clock, separates corrections. At the intended interval of a minute or more, the loop bandwidth is tiny. With a well-matched source, the code settles into alternating between two neighbouring values. The block also flags buffer overflow and underflow, which would cause audible clicks. A one-cycle strobe marks every code change, so that a serial converter interface can forward the new value. When input lock is lost, the code returns to a configured centre, the timer restarts and the error flags are cleared.

Top module: `fill_trim_top`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, trimCode equals the centre value (128 by default), trimStrobe is 0, and both error flags are 0.
- R2: With lockIn high and the hold-off expired, a fill level above HI_MARK (default 320) raises trimCode by one on the next clock edge. A fill level below LO_MARK (default 192) lowers it by one.
- R3: A fill level from LO_MARK to HI_MARK inclusive never changes trimCode.
- R4: Apart from a return to centre, every change of trimCode is exactly +1 or -1.
- R5: A hold-off counter restarts at every step and at loss of lock. The next step can occur no sooner than holdCycles+1 clock edges after the previous one, or after the first locked edge. With the fill level held outside the dead band, consecutive steps are exactly holdCycles+1 edges apart. Time spent in the dead band counts toward the hold-off.
- R6: trimCode saturates at 0 and at its maximum (255 by default). It never wraps, and no strobe is produced when a step is blocked.
- R7: trimStrobe is high for exactly those cycles in which trimCode holds a new value. Every code change, including a return to centre, has one strobe.
- R8: While lockIn is low, trimCode returns to the centre value one edge later, the hold-off counter is held cleared, and both error flags are held at 0.
- R9: pushReq while fillLevel equals DEPTH (512 by default) sets overflowErr from the next cycle. popReq while fillLevel is 0 sets underflowErr from the next cycle. Both flags stay set while locked. A push below DEPTH does not set overflowErr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local output-side clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lockIn | input | 1 | High while the input receiver is locked |
| holdCycles | input | CNT_W | Hold-off length in clock cycles between steps |
| fillLevel | input | FILL_W | Current buffer occupancy, 0 to DEPTH |
| pushReq | input | 1 | Buffer write attempted this cycle |
| popReq | input | 1 | Buffer read attempted this cycle |
| trimCode | output | CODE_W | Frequency-control code for the oscillator converter |
| trimStrobe | output | 1 | One-cycle marker of a new trimCode |
| overflowErr | output | 1 | Sticky flag: write into a full buffer |
| underflowErr | output | 1 | Sticky flag: read from an empty buffer |

## Verification
A hold-off counter that is not restarted, or that is restarted at the wrong time, shows up at the ports as a wrong spacing between strobes. This is visible from the second step of any run with the fill level held outside the dead band. A corrupted code register shows as a jump larger than one, a wrap at either end, or a code change without a strobe. Each of these appears on the clock edge where it happens. Faulty error or recentering state appears one cycle after the triggering push, pop or lock drop. The stimulus exercises each of those edges directly.

// File: rtl/fill_trim_pkg.sv
package fill_trim_pkg;

  // Commands from the decision logic to the code register
  typedef struct packed {
    logic stepUp;
    logic stepDn;
    logic recenter;
  } trimCmd_t;

endpackage

// File: rtl/fill_trim_ctl.sv
module fill_trim_ctl
  import fill_trim_pkg::*;
#(
  parameter int DEPTH   = 512,
  parameter int HI_MARK = 320,
  parameter int LO_MARK = 192,
  parameter int CNT_W   = 32,
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lockIn,
  input  logic [CNT_W-1:0]  holdCycles,
  input  logic [FILL_W-1:0] fillLevel,
  input  logic              pushReq,
  input  logic              popReq,
  input  logic              atMax,
  input  logic              atMin,
  output trimCmd_t          cmd,
  output logic              overflowErr,
  output logic              underflowErr
);

  localparam logic [FILL_W-1:0] HI_LVL   = FILL_W'(HI_MARK);
  localparam logic [FILL_W-1:0] LO_LVL   = FILL_W'(LO_MARK);
  localparam logic [FILL_W-1:0] FULL_LVL = FILL_W'(DEPTH);

  logic [CNT_W-1:0] holdCnt;
  logic             holdDone;
  logic             tooFull;
  logic             tooEmpty;
  logic             stepAny;
  logic             ovfEvent;
  logic             unfEvent;

  // Occupancy zones; the band between the marks is a dead band
  always_comb begin
    tooFull  = fillLevel > HI_LVL;
    tooEmpty = fillLevel < LO_LVL;
    holdDone = holdCnt >= holdCycles;
  end

  always_comb begin
    cmd.recenter = !lockIn;
    cmd.stepUp   = lockIn && holdDone && tooFull  && !atMax;
    cmd.stepDn   = lockIn && holdDone && tooEmpty && !atMin;
    stepAny      = cmd.stepUp || cmd.stepDn;
  end

  // Hold-off timer: saturating up-counter, restarted by each step
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (!lockIn || stepAny) begin
      holdCnt <= '0;
    end else if (holdCnt != '1) begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  always_comb begin
    ovfEvent = pushReq && (fillLevel == FULL_LVL);
    unfEvent = popReq  && (fillLevel == '0);
  end

  // Sticky buffer error flags, cleared while unlocked
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overflowErr  <= 1'b0;
      underflowErr <= 1'b0;
    end else if (!lockIn) begin
      overflowErr  <= 1'b0;
      underflowErr <= 1'b0;
    end else begin
      if (ovfEvent) overflowErr  <= 1'b1;
      if (unfEvent) underflowErr <= 1'b1;
    end
  end

  // R5: with a nonzero hold-off, two steps never fall on adjacent edges
  a_r5_no_back_to_back: assert property (@(posedge clk) disable iff (!rstN)
    (stepAny && holdCycles != '0) |=> !stepAny);

  // R3: dead-band occupancy never produces a step command
  a_r3_dead_band: assert property (@(posedge clk) disable iff (!rstN)
    (!tooFull && !tooEmpty) |-> !(cmd.stepUp || cmd.stepDn));

  // R8: unlock clears timer and flags on the following edge
  a_r8_unlock_clear: assert property (@(posedge clk) disable iff (!rstN)
    !lockIn |=> (holdCnt == '0 && !overflowErr && !underflowErr));

  // R9: a write into a full buffer is flagged one cycle later
  a_r9_overflow_flag: assert property (@(posedge clk) disable iff (!rstN)
    (lockIn && ovfEvent) |=> overflowErr);

  // R9: a read from an empty buffer is flagged one cycle later
  a_r9_underflow_flag: assert property (@(posedge clk) disable iff (!rstN)
    (lockIn && unfEvent) |=> underflowErr);

endmodule

// File: rtl/fill_trim_dp.sv
module fill_trim_dp
  import fill_trim_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int CODE_CENTER = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  trimCmd_t          cmd,
  output logic [CODE_W-1:0] codeQ,
  output logic              strobeQ,
  output logic              atMax,
  output logic              atMin
);

  localparam logic [CODE_W-1:0] CENTER_C = CODE_W'(CODE_CENTER);
  localparam logic [CODE_W-1:0] MAX_C    = '1;
  localparam logic [CODE_W-1:0] MIN_C    = '0;

  logic [CODE_W-1:0] codeNext;

  always_comb begin
    atMax = codeQ == MAX_C;
    atMin = codeQ == MIN_C;
  end

  always_comb begin
    codeNext = codeQ;
    if (cmd.recenter) begin
      codeNext = CENTER_C;
    end else if (cmd.stepUp && !atMax) begin
      codeNext = codeQ + 1'b1;
    end else if (cmd.stepDn && !atMin) begin
      codeNext = codeQ - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeQ   <= CENTER_C;
      strobeQ <= 1'b0;
    end else begin
      codeQ   <= codeNext;
      strobeQ <= codeNext != codeQ;
    end
  end

  // R4: outside recentering, the code moves by one LSB at most
  a_r4_one_lsb: assert property (@(posedge clk) disable iff (!rstN)
    ((codeQ != $past(codeQ)) && !$past(cmd.recenter)) |->
      (codeQ == $past(codeQ) + 1'b1 || codeQ == $past(codeQ) - 1'b1));

  // R6: no wrap from the top end
  a_r6_no_wrap_top: assert property (@(posedge clk) disable iff (!rstN)
    (codeQ == MAX_C && !cmd.recenter) |=> codeQ == MAX_C || codeQ == MAX_C - 1'b1);

  // R6: no wrap from the bottom end
  a_r6_no_wrap_bottom: assert property (@(posedge clk) disable iff (!rstN)
    (codeQ == MIN_C && !cmd.recenter) |=> codeQ == MIN_C || codeQ == MIN_C + 1'b1);

  // R7: strobe marks exactly the cycles with a new code
  a_r7_strobe_matches: assert property (@(posedge clk) disable iff (!rstN)
    strobeQ == (codeQ != $past(codeQ)));

  // R8: recentering lands on the centre code
  a_r8_recenter: assert property (@(posedge clk) disable iff (!rstN)
    cmd.recenter |=> codeQ == CENTER_C);

endmodule

// File: rtl/fill_trim_top.sv
module fill_trim_top
  import fill_trim_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int CODE_CENTER = 128,
  parameter int DEPTH       = 512,
  parameter int HI_MARK     = 320,
  parameter int LO_MARK     = 192,
  parameter int CNT_W       = 32,
  localparam int FILL_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lockIn,
  input  logic [CNT_W-1:0]  holdCycles,
  input  logic [FILL_W-1:0] fillLevel,
  input  logic              pushReq,
  input  logic              popReq,
  output logic [CODE_W-1:0] trimCode,
  output logic              trimStrobe,
  output logic              overflowErr,
  output logic              underflowErr
);

  trimCmd_t cmd;
  logic     atMax;
  logic     atMin;

  fill_trim_ctl #(
    .DEPTH  (DEPTH),
    .HI_MARK(HI_MARK),
    .LO_MARK(LO_MARK),
    .CNT_W  (CNT_W)
  ) u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .lockIn      (lockIn),
    .holdCycles  (holdCycles),
    .fillLevel   (fillLevel),
    .pushReq     (pushReq),
    .popReq      (popReq),
    .atMax       (atMax),
    .atMin       (atMin),
    .cmd         (cmd),
    .overflowErr (overflowErr),
    .underflowErr(underflowErr)
  );

  fill_trim_dp #(
    .CODE_W     (CODE_W),
    .CODE_CENTER(CODE_CENTER)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cmd),
    .codeQ  (trimCode),
    .strobeQ(trimStrobe),
    .atMax  (atMax),
    .atMin  (atMin)
  );

endmodule

// File: tb/sim_fill_trim_top.sv
`timescale 1ns/1ps
module sim_fill_trim_top;

  localparam int CNT_W  = 32;
  localparam int FILL_W = 10;
  localparam int CENTER = 128;

  typedef struct {
    int code;
    int gap;
  } item_t;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              lockIn = 1'b1;
  logic [CNT_W-1:0]  holdCycles = 32'd4;
  logic [FILL_W-1:0] fillLevel = 10'd256;
  logic              pushReq = 1'b0;
  logic              popReq = 1'b0;
  logic [7:0]        trimCode;
  logic              trimStrobe;
  logic              overflowErr;
  logic              underflowErr;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  int    lastStrobe = 0;
  int    prevCode = CENTER;
  bit    monOn = 0;
  bit    done = 0;
  item_t expQ[$];

  always #5 clk = ~clk;

  fill_trim_top u0 (
    .clk         (clk),
    .rstN        (rstN),
    .lockIn      (lockIn),
    .holdCycles  (holdCycles),
    .fillLevel   (fillLevel),
    .pushReq     (pushReq),
    .popReq      (popReq),
    .trimCode    (trimCode),
    .trimStrobe  (trimStrobe),
    .overflowErr (overflowErr),
    .underflowErr(underflowErr)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic expect_item(input int code, input int gap);
    item_t it;
    it.code = code;
    it.gap  = gap;
    expQ.push_back(it);
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Monitor: pops the scoreboard on every strobe
  always @(negedge clk) begin
    if (monOn) begin
      if (trimStrobe) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R7 unexpected strobe", int'(trimCode), -1);
        end else begin
          item_t it;
          it = expQ.pop_front();
          chk(int'(trimCode) == it.code, "R2/R4 code after step", int'(trimCode), it.code);
          if (it.gap >= 0)
            chk(cyc - lastStrobe == it.gap, "R5 step spacing", cyc - lastStrobe, it.gap);
        end
        lastStrobe = cyc;
      end
      if (int'(trimCode) != prevCode && !trimStrobe)
        chk(1'b0, "R7 code change without strobe", int'(trimCode), prevCode);
      prevCode = int'(trimCode);
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", cyc, 150000);
      summary();
      $finish;
    end
  end

  initial begin
    wait_neg(3);
    chk(trimCode == 8'd128, "R1 reset code", int'(trimCode), 128);
    chk(trimStrobe == 1'b0, "R1 reset strobe", int'(trimStrobe), 0);
    chk(overflowErr == 1'b0 && underflowErr == 1'b0, "R1 reset flags",
        int'({overflowErr, underflowErr}), 0);
    rstN = 1'b1;
    monOn = 1;
    @(negedge clk);
    chk(trimCode == 8'd128 && !trimStrobe, "R1 first cycle after reset", int'(trimCode), 128);

    // Dead band long enough for the hold-off to expire
    wait_neg(20);

    // R2 up steps with hold 4: spacing 5
    expect_item(129, -1); expect_item(130, 5); expect_item(131, 5);
    fillLevel = 10'd400;
    wait_neg(11);
    fillLevel = 10'd256;
    wait_neg(20);
    chk(trimCode == 8'd131 && expQ.size() == 0, "R2 three up steps", int'(trimCode), 131);

    // R2 down steps
    expect_item(130, -1); expect_item(129, 5); expect_item(128, 5);
    fillLevel = 10'd100;
    wait_neg(11);
    fillLevel = 10'd256;
    wait_neg(5);
    chk(trimCode == 8'd128 && expQ.size() == 0, "R2 three down steps", int'(trimCode), 128);

    // R3 dead band edges, with hold-off long expired
    fillLevel = 10'd320;
    wait_neg(20);
    chk(trimCode == 8'd128, "R3 fill at upper mark", int'(trimCode), 128);
    fillLevel = 10'd192;
    wait_neg(20);
    chk(trimCode == 8'd128, "R3 fill at lower mark", int'(trimCode), 128);
    fillLevel = 10'd256;

    // R5 zero hold-off: steps on consecutive edges
    holdCycles = 32'd0;
    @(negedge clk);
    expect_item(129, -1); expect_item(130, 1); expect_item(131, 1);
    fillLevel = 10'd400;
    wait_neg(3);
    fillLevel = 10'd256;
    wait_neg(3);
    chk(trimCode == 8'd131 && expQ.size() == 0, "R5 zero hold-off run", int'(trimCode), 131);

    // R6 saturation at the top
    for (int c = 132; c <= 255; c++) expect_item(c, (c == 132) ? -1 : 1);
    fillLevel = 10'd400;
    wait_neg(200);
    chk(trimCode == 8'd255, "R6 saturate at max", int'(trimCode), 255);
    chk(expQ.size() == 0, "R6 all up steps seen", expQ.size(), 0);

    // R6 saturation at the bottom
    for (int c = 254; c >= 0; c--) expect_item(c, (c == 254) ? -1 : 1);
    fillLevel = 10'd100;
    wait_neg(300);
    chk(trimCode == 8'd0, "R6 saturate at min", int'(trimCode), 0);
    chk(expQ.size() == 0, "R6 all down steps seen", expQ.size(), 0);

    // R9 error flags, with steps disabled by a huge hold-off
    fillLevel = 10'd256;
    holdCycles = '1;
    @(negedge clk);
    fillLevel = 10'd511; pushReq = 1'b1;
    @(negedge clk);
    pushReq = 1'b0;
    chk(overflowErr == 1'b0, "R9 push below full", int'(overflowErr), 0);
    fillLevel = 10'd512; pushReq = 1'b1;
    @(negedge clk);
    pushReq = 1'b0;
    chk(overflowErr == 1'b1, "R9 overflow set", int'(overflowErr), 1);
    chk(underflowErr == 1'b0, "R9 no underflow yet", int'(underflowErr), 0);
    fillLevel = 10'd0;
    @(negedge clk);
    chk(underflowErr == 1'b0, "R9 empty without pop", int'(underflowErr), 0);
    popReq = 1'b1;
    @(negedge clk);
    popReq = 1'b0;
    chk(underflowErr == 1'b1, "R9 underflow set", int'(underflowErr), 1);
    wait_neg(3);
    chk(overflowErr && underflowErr, "R9 flags sticky", int'({overflowErr, underflowErr}), 3);
    chk(trimCode == 8'd0, "R9 no step during flag test", int'(trimCode), 0);

    // R8 loss of lock: recentre, clear flags, ignore pushes into full
    expect_item(128, -1);
    fillLevel = 10'd512; pushReq = 1'b1;
    lockIn = 1'b0;
    @(negedge clk);
    chk(trimCode == 8'd128, "R8 recentre on unlock", int'(trimCode), 128);
    chk(!overflowErr && !underflowErr, "R8 flags cleared", int'({overflowErr, underflowErr}), 0);
    wait_neg(5);
    chk(!overflowErr && !underflowErr, "R8 flags held while unlocked",
        int'({overflowErr, underflowErr}), 0);
    chk(trimCode == 8'd128, "R8 code held at centre", int'(trimCode), 128);
    pushReq = 1'b0;

    // R5 relock: first step on edge holdCycles+1
    holdCycles = 32'd3;
    fillLevel = 10'd400;
    expect_item(129, -1);
    lockIn = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      chk(trimCode == 8'd128, "R5 hold-off after relock", int'(trimCode), 128);
    end
    @(negedge clk);
    fillLevel = 10'd256;
    chk(trimCode == 8'd129, "R5 first step after relock", int'(trimCode), 129);
    wait_neg(10);
    chk(expQ.size() == 0, "R7 scoreboard drained", expQ.size(), 0);

    done = 1;
    summary();
    $finish;
  end

endmodule